// File: doc/BRIEF.md
# Pin Interrupt Edge/Level Controller

This block raises one interrupt request line per input pin for up to eight pins that have already been selected upstream. Each channel is set for edge or level sensitivity. In edge mode the channel records rising and falling transitions and holds a pending interrupt until software clears it. In level mode the interrupt follows the pin while the pin sits at a programmed active level.

Software reaches the block over a simple synchronous register bus. `addr` is a word index, equal to the byte offset divided by four. A write lands on the rising clock edge where `wr_en` is high. `rdata` is a combinational function of `addr`. The two enable registers each have a direct-write view, a write-one-to-set alias and a write-one-to-clear alias. The meaning of an enable bit depends on the mode of its channel. Every pin passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with a copy registered one cycle later.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, all readable registers read 0 and `irq` is 0.
- R2: The mode register (byte offset 0x000) holds one bit per channel: 0 selects edge sensitivity and 1 selects level sensitivity.
- R3: The rise/level enable register (0x004) can be written directly. Writing 1s to the alias at 0x008 sets the matching bits and writing 1s to the alias at 0x00C clears them. Bits written as 0 through an alias are left unchanged.
- R4: The fall/active-level register (0x010) has a set alias at 0x014 and a clear alias at 0x018, with the same write-one semantics as R3.
- R5: A synchronized rising transition sets the channel's bit in the rise record (0x01C), and a falling transition sets its bit in the fall record (0x020). A transition that reaches the pin input before a clock edge shows in the record after the third rising clock edge, whether or not the channel is enabled.
- R6: An edge-mode channel becomes pending in the status register (0x024) only for an edge whose enable is set: a rising edge needs bit n of 0x004 and a falling edge needs bit n of 0x010. `irq[n]` always equals status bit n.
- R7: Writing 1 to a bit of the rise or fall record clears that bit. Bits written as 0 are kept.
- R8: For an edge-mode channel, writing 1 to its status bit clears the pending interrupt.
- R9: A level-mode channel is active while its 0x004 bit is set and the synchronized pin equals its 0x010 bit (1 means active high). Writes to status do not clear it.
- R10: Reads of the write-only aliases (0x008, 0x00C, 0x014, 0x018), reads of unmapped words, and all bits above the channel count read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NCH | Selected pins, asynchronous |
| addr | input | ADDR_W | Word index of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| irq | output | NCH | Interrupt request per channel |

## Verification
The assertions assume that `addr`, `wr_en` and `wdata` are known and stable around every clock edge, and that at most one register is written per cycle. `pin_in` may change at any time. The stimulus changes every input just after a clock edge. It holds each pin value for at least three clocks, so that every transition passes through the synchronizer before the next check reads the result.

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    irq
);
  localparam logic [ADDR_W-1:0] W_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] W_ENR   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] W_SETR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] W_CLRR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] W_ENF   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] W_SETF  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] W_CLRF  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] W_RISE  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] W_FALL  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] W_STAT  = ADDR_W'(9);

  logic [NCH-1:0] meta, sync, prev;
  logic [NCH-1:0] mode, en_r, en_f, rise_q, fall_q, pend;
  logic [NCH-1:0] wbits, rise_det, fall_det, lvl, status;

  assign wbits    = wdata[NCH-1:0];
  assign rise_det = sync & ~prev;
  assign fall_det = ~sync & prev;
  assign lvl      = en_r & ~(sync ^ en_f);
  assign status   = (mode & lvl) | (~mode & pend);
  assign irq      = status;

  function automatic logic [NCH-1:0] hitmask(input logic [ADDR_W-1:0] a);
    return (wr_en && addr == a) ? wbits : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      prev <= '0;
    end else begin
      meta <= pin_in;
      sync <= meta;
      prev <= sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      en_r   <= '0;
      en_f   <= '0;
      rise_q <= '0;
      fall_q <= '0;
      pend   <= '0;
    end else begin
      if (wr_en && addr == W_MODE) mode <= wbits;
      if (wr_en && addr == W_ENR) en_r <= wbits;
      else en_r <= (en_r | hitmask(W_SETR)) & ~hitmask(W_CLRR);
      if (wr_en && addr == W_ENF) en_f <= wbits;
      else en_f <= (en_f | hitmask(W_SETF)) & ~hitmask(W_CLRF);
      rise_q <= (rise_q & ~hitmask(W_RISE)) | rise_det;
      fall_q <= (fall_q & ~hitmask(W_FALL)) | fall_det;
      pend   <= ((pend & ~hitmask(W_STAT)) | (rise_det & en_r) | (fall_det & en_f)) & ~mode;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      W_MODE:  rdata[NCH-1:0] = mode;
      W_ENR:   rdata[NCH-1:0] = en_r;
      W_ENF:   rdata[NCH-1:0] = en_f;
      W_RISE:  rdata[NCH-1:0] = rise_q;
      W_FALL:  rdata[NCH-1:0] = fall_q;
      W_STAT:  rdata[NCH-1:0] = status;
      default: rdata = '0;
    endcase
  end
endmodule

module pin_irq_ctrl_chk #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    mode,
  input logic [NCH-1:0]    en_r,
  input logic [NCH-1:0]    en_f
);
  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:NCH] == '0);
  // R10
  alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(2) || addr == ADDR_W'(3) || addr == ADDR_W'(5) || addr == ADDR_W'(6))
    |-> rdata == '0);
  // R6
  irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == ADDR_W'(9) |-> rdata[NCH-1:0] == irq);
  // R3
  set_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(2)) |=> en_r == ($past(en_r) | $past(wdata[NCH-1:0])));
  // R4
  clr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(6)) |=> en_f == ($past(en_f) & ~$past(wdata[NCH-1:0])));
  // R9
  level_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & mode & ~en_r) == '0);
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .irq(irq), .mode(mode), .en_r(en_r), .en_f(en_f)
);

// File: tb/pin_irq_ctrl_test.sv
`timescale 1ns/1ps
module pin_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int          q_addr[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  bit          q_irq[$];

  always #2.5 clk = ~clk;

  pin_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      automatic int          a   = q_addr.pop_front();
      automatic logic [31:0] e   = q_exp.pop_front();
      automatic string       t   = q_tag.pop_front();
      automatic bit          isi = q_irq.pop_front();
      automatic logic [31:0] act = isi ? {24'h0, irq} : rdata;
      checks++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s %s addr=%0d actual=%h expected=%h", t, isi ? "irq" : "rdata", a, act, e);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = 4'(a); wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input int a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    addr = 4'(a);
    q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(t); q_irq.push_back(1'b0);
  endtask

  task automatic expect_irq(input logic [7:0] e, input string t);
    @(posedge clk); #1;
    q_addr.push_back(-1); q_exp.push_back({24'h0, e}); q_tag.push_back(t); q_irq.push_back(1'b1);
  endtask

  task automatic drive_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    for (int i = 0; i < 10; i++) expect_rd(i, 32'h0, "R1");
    expect_irq(8'h00, "R1");
    // R2 mode register, R10 upper bits
    wr(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0000_00FF, "R2/R10");
    wr(0, 32'h0000_00F0);
    expect_rd(0, 32'h0000_00F0, "R2");
    // R3 rise/level enable with aliases
    wr(1, 32'h0F);
    wr(2, 32'h30);
    expect_rd(1, 32'h3F, "R3");
    wr(3, 32'h03);
    expect_rd(1, 32'h3C, "R3");
    expect_rd(2, 32'h0, "R10");
    expect_rd(3, 32'h0, "R10");
    // R4 fall/active-level with aliases
    wr(4, 32'h81);
    wr(5, 32'h06);
    expect_rd(4, 32'h87, "R4");
    wr(6, 32'h81);
    expect_rd(4, 32'h06, "R4");
    expect_rd(5, 32'h0, "R10");
    expect_rd(6, 32'h0, "R10");
    expect_rd(12, 32'h0, "R10");
    // edge mode scenario
    wr(0, 0); wr(1, 32'h01); wr(4, 32'h02);
    drive_pins(8'h03);
    expect_rd(7, 32'h03, "R5");
    expect_rd(8, 32'h00, "R5");
    expect_rd(9, 32'h01, "R6");
    expect_irq(8'h01, "R6");
    drive_pins(8'h00);
    expect_rd(8, 32'h03, "R5");
    expect_rd(9, 32'h03, "R6");
    wr(7, 32'h01);
    expect_rd(7, 32'h02, "R7");
    wr(8, 32'h02);
    expect_rd(8, 32'h01, "R7");
    wr(9, 32'h01);
    expect_rd(9, 32'h02, "R8");
    expect_irq(8'h02, "R8");
    wr(7, 32'hFF); wr(8, 32'hFF); wr(9, 32'hFF);
    expect_rd(9, 32'h0, "R8");
    // level mode on channel 4
    wr(0, 32'h10); wr(2, 32'h10); wr(5, 32'h10);
    expect_rd(9, 32'h0, "R9");
    drive_pins(8'h10);
    expect_rd(9, 32'h10, "R9");
    expect_irq(8'h10, "R9");
    wr(9, 32'h10);
    expect_rd(9, 32'h10, "R9");
    wr(6, 32'h10);
    expect_rd(9, 32'h0, "R9");
    drive_pins(8'h00);
    expect_rd(9, 32'h10, "R9");
    expect_irq(8'h10, "R9");
    wr(3, 32'h10);
    expect_rd(9, 32'h0, "R9");
    expect_irq(8'h00, "R9");
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule